// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software talks to it over a simple register bus that completes each 32-bit read or write in one cycle. Software first picks two timeout codes. The first code sets the length of the first countdown after the watchdog is armed. The second code sets the length of every countdown after that. Software then arms the watchdog. While the system is healthy, software writes a magic word to a restart register, which refills the down-counter. If software stops doing so, the counter reaches zero. The block then raises a reset request that stays high until the block itself is reset.

Each timeout code `c` selects a period of `2^(BASE_EXP+c)` clock cycles. With the default `BASE_EXP` of 16, the sixteen codes give periods from 2^16 to 2^31 cycles. Once armed, the watchdog cannot be disarmed by software. Only a reset clears the arm bit. The current count can be read at any time.

Top module: `wdog_timer`

## Requirements
- R1: The register map is byte-addressed as follows: arm register at 0x0, period register at 0x4, read-only count at 0x8 and restart register at 0xC. A read of any other offset returns 0. A read at 0xC also returns 0. Writes to 0x8 or to any unmapped offset change nothing. `bus_rdata` is 0 when no read is presented.
- R2: Writing 1 to bit 0 of the arm register arms the watchdog. Bit 0 of the arm register reads back the arm state. Once the watchdog is armed, writing 0 there leaves it armed.
- R3: Bits [3:0] of the period register hold the running code and bits [7:4] hold the first-period code. A read returns both codes in those positions, with bits [31:8] reading 0.
- R4: Arming loads the counter with `2^(BASE_EXP+first-period code)-1`. The count register reads this value right after the arming write.
- R5: While armed and not expired, the counter drops by one on every clock edge that carries no reload.
- R6: A write of exactly 0x00000076 to the restart register, while armed, reloads `2^(BASE_EXP+running code)-1`. Any other data written there leaves the counter counting down. A restart write while disarmed leaves the count at 0.
- R7: A write to the period register does not alter a countdown in progress. The new running code is used from the next restart onward.
- R8: `rst_req` rises on the edge after the one at which the count reaches 0. This is `2^(BASE_EXP+code)` edges after the loading edge.
- R9: Once raised, `rst_req` stays high. The count stays frozen at 0, and restart writes have no effect.
- R10: After reset, the arm bit, both codes, the count and `rst_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access present this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| rst_req | output | 1 | System reset request, held until reset |

## Verification
The assertions assume that the bus never presents a read and a write in the same cycle. They also assume that `bus_addr` and `bus_wdata` are stable whenever `bus_sel` is high at a clock edge. The bench holds to this by driving each access on the falling edge and holding it for exactly one rising edge. The bench returns `bus_sel` low before the next access. Every timing property also assumes that `BASE_EXP` is at least 1, so that every reload is nonzero. The bench shrinks `BASE_EXP` to 2 so that countdowns to expiry fit in a short run.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, magic word and register-select type for the watchdog.
// Assumes byte offsets fit into the address width chosen at the top.
package wdog_pkg;
    localparam int DATA_W      = 32;
    localparam int CODE_W      = 4;
    localparam int NUM_CODES   = 1 << CODE_W;
    localparam int OFS_ARM     = 'h0;
    localparam int OFS_PERIOD  = 'h4;
    localparam int OFS_COUNT   = 'h8;
    localparam int OFS_RESTART = 'hC;
    localparam logic [DATA_W-1:0] RESTART_MAGIC = 32'h0000_0076;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ARM,
        RSEL_PERIOD,
        RSEL_COUNT,
        RSEL_RESTART
    } reg_sel_e;
endpackage

// File: rtl/wdog_period_lut.sv
// Module: maps a 4-bit timeout code to the reload value 2^(BASE_EXP+code)-1.
// Assumes CNT_W >= BASE_EXP + NUM_CODES - 1 so that the longest period fits.
module wdog_period_lut
    import wdog_pkg::*;
#(
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + NUM_CODES
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  reload
);
    logic [CNT_W-1:0] table_q [NUM_CODES];

    // One constant entry per code, computed from the parameters.
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
        localparam logic [CNT_W-1:0] ENTRY =
            CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
        assign table_q[g] = ENTRY;
    end

    // Select the entry for the requested code.
    assign reload = table_q[code];
endmodule

// File: rtl/wdog_regs.sv
// Module: bus decode, arm latch, period codes and read-back mux.
// Assumes one access per cycle. The read data is combinational from the registers.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    output logic              armed,
    output logic [CODE_W-1:0] run_code,
    output logic [CODE_W-1:0] first_code,
    output logic              arm_pulse,
    output logic              restart_pulse
);
    reg_sel_e sel;
    logic     wr_en;
    logic     rd_en;

    // Decode the byte offset into a register select.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_ARM))           sel = RSEL_ARM;
        else if (bus_addr == ADDR_W'(OFS_PERIOD))   sel = RSEL_PERIOD;
        else if (bus_addr == ADDR_W'(OFS_COUNT))    sel = RSEL_COUNT;
        else if (bus_addr == ADDR_W'(OFS_RESTART))  sel = RSEL_RESTART;
        else                                        sel = RSEL_NONE;
    end

    assign wr_en = bus_sel &&  bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    // An arming write is only a pulse when the watchdog is still disarmed.
    assign arm_pulse     = wr_en && (sel == RSEL_ARM) && bus_wdata[0] && !armed;
    // A restart requires the exact magic word and an armed watchdog.
    assign restart_pulse = wr_en && (sel == RSEL_RESTART) &&
                           (bus_wdata == RESTART_MAGIC) && armed;

    // Arm latch: set by software, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (arm_pulse) armed <= 1'b1;
    end

    // Period codes: both fields are written together from one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_code   <= '0;
            first_code <= '0;
        end else if (wr_en && (sel == RSEL_PERIOD)) begin
            run_code   <= bus_wdata[CODE_W-1:0];
            first_code <= bus_wdata[2*CODE_W-1:CODE_W];
        end
    end

    // Read-back mux. The restart register, unmapped offsets and idle cycles all return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                RSEL_ARM:    bus_rdata = DATA_W'(armed);
                RSEL_PERIOD: bus_rdata = DATA_W'({first_code, run_code});
                RSEL_COUNT:  bus_rdata = DATA_W'(count);
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Module: down-counter with parallel load and a sticky expiry flag.
// Assumes load and restart never coincide. Every load value is nonzero.
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             load_first,
    input  logic             load_run,
    input  logic [CNT_W-1:0] first_val,
    input  logic [CNT_W-1:0] run_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    // Count down, reload on request, and freeze once expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            if (load_first)
                count <= first_val;
            else if (load_run)
                count <= run_val;
            else if (armed) begin
                if (count == '0) expired <= 1'b1;
                else             count   <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_timer.sv
// Module: watchdog top. It joins the register file, two period tables and the counter.
// Assumes a single clock domain and BASE_EXP >= 1.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int BASE_EXP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req
);
    localparam int CNT_W = BASE_EXP + NUM_CODES;

    logic              en_q;
    logic [CODE_W-1:0] run_code;
    logic [CODE_W-1:0] first_code;
    logic              arm_pulse;
    logic              restart_pulse;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  first_val;
    logic [CNT_W-1:0]  run_val;

    wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .count         (cnt_q),
        .armed         (en_q),
        .run_code      (run_code),
        .first_code    (first_code),
        .arm_pulse     (arm_pulse),
        .restart_pulse (restart_pulse)
    );

    wdog_period_lut #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_lut_first (
        .code   (first_code),
        .reload (first_val)
    );

    wdog_period_lut #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_lut_run (
        .code   (run_code),
        .reload (run_val)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (en_q),
        .load_first (arm_pulse),
        .load_run   (restart_pulse),
        .first_val  (first_val),
        .run_val    (run_val),
        .count      (cnt_q),
        .expired    (rst_req)
    );
endmodule

// File: rtl/wdog_timer_sva.sv
// Module: assertion checker for wdog_timer, attached through bind.
// Assumes bus inputs are stable around each rising edge.
module wdog_timer_sva #(
    parameter int ADDR_W   = 4,
    parameter int BASE_EXP = 16,
    parameter int CNT_W    = BASE_EXP + 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rst_req,
    input logic              en_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic kick_wr;
    logic arm_wr;
    logic unmapped_rd;

    assign kick_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'('hC)) &&
                     (bus_wdata == 32'h76);
    assign arm_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'('h0)) && bus_wdata[0];
    assign unmapped_rd = bus_sel && !bus_wr &&
                         (bus_addr != ADDR_W'('h0)) && (bus_addr != ADDR_W'('h4)) &&
                         (bus_addr != ADDR_W'('h8));

    // R1: unmapped offsets and the restart offset read as zero
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_rd |-> (bus_rdata == 32'h0));

    // R2: arm state never falls without reset
    a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);

    // R4: an arming write leaves the counter armed with a nonzero count
    a_r4_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && !en_q) |=> (en_q && (cnt_q != '0)));

    // R5: one step down per edge while running with no reload
    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !rst_req && (cnt_q != '0) && !kick_wr)
        |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R8: reaching zero without a restart raises the request next edge
    a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !rst_req && (cnt_q == '0) && !kick_wr) |=> rst_req);

    // R9: the request is held and the count is frozen
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rst_req && $stable(cnt_q)));

    // R10: while disarmed the counter idles at zero with no request
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> ((cnt_q == '0) && !rst_req));
endmodule

bind wdog_timer wdog_timer_sva #(
    .ADDR_W(ADDR_W), .BASE_EXP(BASE_EXP), .CNT_W(BASE_EXP + 16)
) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .en_q(en_q), .cnt_q(cnt_q)
);

// File: tb/wdog_timer_bench.sv
// Bench: directed tests for wdog_timer with BASE_EXP shrunk to 2.
module wdog_timer_bench;
    localparam int BEXP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    wdog_timer #(.ADDR_W(4), .BASE_EXP(BEXP)) u_wdog_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    function automatic logic [31:0] period_of(int code);
        return (32'd1 << (BEXP + code)) - 32'd1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; occupies exactly one rising edge.
    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Called at a falling edge; no rising edge passes.
    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bus_read(4'h0, d); check("R10 arm after reset", d, 32'h0);
        bus_read(4'h4, d); check("R10 period after reset", d, 32'h0);
        bus_read(4'h8, d); check("R10 count after reset", d, 32'h0);
        check("R10 rst_req after reset", 32'(rst_req), 32'h0);
        bus_read(4'h2, d); check("R1 unmapped 0x2 reads 0", d, 32'h0);
        bus_read(4'hC, d); check("R1 restart reads 0", d, 32'h0);
    endtask

    task automatic t_disarmed_access();
        logic [31:0] d;
        bus_write(4'h4, 32'hFFFF_1234);
        bus_read(4'h4, d); check("R3 period readback", d, 32'h34);
        bus_write(4'h8, 32'h55);
        bus_write(4'h6, 32'h1);
        bus_read(4'h8, d); check("R1 write to count ignored", d, 32'h0);
        bus_read(4'h0, d); check("R1 unmapped write does not arm", d, 32'h0);
        bus_write(4'hC, 32'h76);
        bus_read(4'h8, d); check("R6 restart while disarmed", d, 32'h0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, d); check("R2 zero write leaves disarmed", d, 32'h0);
    endtask

    task automatic t_run_and_expire();
        logic [31:0] d;
        bus_write(4'h4, 32'h10);              // first code 1, running code 0
        bus_write(4'h0, 32'h1);
        bus_read(4'h8, d); check("R4 first period load", d, period_of(1));
        bus_read(4'h0, d); check("R2 arm reads 1", d, 32'h1);
        wait_cyc(3);
        bus_read(4'h8, d); check("R5 three steps down", d, 32'd4);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, d); check("R2 arm is sticky", d, 32'h1);
        bus_read(4'h8, d); check("R5 count after write", d, 32'd3);
        bus_write(4'hC, 32'h77);
        bus_read(4'h8, d); check("R6 wrong magic ignored", d, 32'd2);
        bus_write(4'hC, 32'h176);
        bus_read(4'h8, d); check("R6 magic needs whole word", d, 32'd1);
        bus_write(4'hC, 32'h76);
        bus_read(4'h8, d); check("R6 restart uses running code", d, period_of(0));
        bus_write(4'h4, 32'h02);
        bus_read(4'h8, d); check("R7 period write keeps count", d, 32'd2);
        bus_write(4'hC, 32'h76);
        bus_read(4'h8, d); check("R7 new code at next restart", d, period_of(2));
        wait_cyc(15);
        bus_read(4'h8, d); check("R8 count at zero", d, 32'h0);
        check("R8 no request yet", 32'(rst_req), 32'h0);
        wait_cyc(1);
        check("R8 request raised", 32'(rst_req), 32'h1);
        bus_write(4'hC, 32'h76);
        bus_read(4'h8, d); check("R9 restart after expiry ignored", d, 32'h0);
        wait_cyc(5);
        check("R9 request held", 32'(rst_req), 32'h1);
        do_reset();
        check("R10 request cleared by reset", 32'(rst_req), 32'h0);
        bus_read(4'h0, d); check("R10 arm cleared by reset", d, 32'h0);
    endtask

    task automatic t_long_first();
        logic [31:0] d;
        bus_write(4'h4, 32'hF0);
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h8, d); check("R4 longest first period", d, period_of(15));
        bus_read(4'h4, d); check("R3 first code field", d, 32'hF0);
        do_reset();
    endtask

    initial begin
        wait_cyc(1);
        do_reset();
        t_reset_state();
        t_disarmed_access();
        t_run_and_expire();
        t_long_first();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule